// File: doc/BRIEF.md
# Virtual-Physical Tagged Issue Queue with Register Stealing

This block is an out-of-order issue queue whose operands are named by virtual-physical tags rather than by physical registers. A physical register is bound to an instruction only when it completes execution. Because the binding can fail or be undone, entries are never freed at issue or completion. Each instruction stays resident, in program order, until it retires from the head of a circular buffer. When it retires, it holds a finished result and a physical register.

When an instruction completes and the allocator has no free register, the queue looks for the youngest finished instruction that is younger than the requester and still holds a register. If it finds one, it takes that register. The victim loses its register and its finished state, and its destination tag is broadcast. Any unissued consumer waiting on that tag drops its ready bit, and the victim is scheduled to run again. Consumers that have already issued are left alone. If no younger holder exists, the requester itself is sent back to run again.

A scheduler drives select through an issue enable. A wakeup port marks source tags ready. Two counters record steals and re-executions.

Top module: `issue_queue_vp`

## Requirements
- R1: After reset the queue is empty: `disp_ready` is 1, `iss_valid` and `ret_fire` are 0, and both counters read 0.
- R2: A dispatch is accepted into slot `disp_idx` when `disp_valid` and `disp_ready` are both high. `disp_ready` is low exactly when all DEPTH slots are occupied.
- R3: With `iss_en` high, `iss_valid` reports the oldest occupied, unissued entry whose two sources are both ready. Age is measured from the retire head. An entry is issued once per execution attempt.
- R4: A wakeup marks every unissued source matching `wk_tag` as ready. If a victim broadcast carries the same tag in the same cycle, the victim broadcast wins and the source is left not ready.
- R5: Issue and completion free no slot. A slot is released only by retirement.
- R6: A completion with `cmp_grant` low when no younger finished register holder exists sends the requester back to the unissued state. `cmp_got` is 0 in this case, and `reexec_cnt` increments by 1.
- R7: A completion with `cmp_grant` low steals from the youngest finished holder younger than the requester. In that cycle `cmp_stole` and `vic_valid` are 1, `vic_idx` and `vic_tag` name the victim, and `cmp_preg_out` carries the victim's register. The requester becomes finished. `steal_cnt` and `reexec_cnt` each increment by 1.
- R8: A victim broadcast clears the matching source ready bits of unissued entries only. Entries that have already issued are not selected again.
- R9: A victim returns to the unfinished, unissued state and is selected again. Its own sources keep their readiness.
- R10: Finished holders older than the requester are never chosen as victims.
- R11: Retirement happens in order. With `ret_en` high, `ret_fire` is 1 only if the head entry is finished and holds a register, and `ret_dst` and `ret_preg` report that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_dst | input | TW | Destination virtual-physical tag |
| disp_src0 | input | TW | First source tag |
| disp_rdy0 | input | 1 | First source already ready |
| disp_src1 | input | TW | Second source tag |
| disp_rdy1 | input | 1 | Second source already ready |
| disp_ready | output | 1 | A slot is free |
| disp_idx | output | $clog2(DEPTH) | Slot a dispatch would occupy |
| iss_en | input | 1 | Select enable from the scheduler |
| iss_valid | output | 1 | An entry issues this cycle |
| iss_idx | output | $clog2(DEPTH) | Issuing slot |
| iss_dst | output | TW | Destination tag of the issuing slot |
| cmp_valid | input | 1 | Completion of an issued slot |
| cmp_idx | input | $clog2(DEPTH) | Completing slot |
| cmp_grant | input | 1 | Allocator supplies a free register |
| cmp_preg | input | PW | Register supplied by the allocator |
| cmp_got | output | 1 | Requester obtains a register |
| cmp_preg_out | output | PW | Register the requester obtains |
| cmp_stole | output | 1 | Register was taken from a victim |
| vic_valid | output | 1 | Victim broadcast |
| vic_idx | output | $clog2(DEPTH) | Victim slot |
| vic_tag | output | TW | Victim destination tag |
| wk_valid | input | 1 | Wakeup broadcast |
| wk_tag | input | TW | Tag being woken |
| ret_en | input | 1 | Retirement allowed this cycle |
| ret_fire | output | 1 | Head entry retires |
| ret_dst | output | TW | Retiring destination tag |
| ret_preg | output | PW | Retiring physical register |
| steal_cnt | output | CW | Steals performed |
| reexec_cnt | output | CW | Re-executions forced |

## Verification
A corrupted ready bit shows on the next enabled select cycle. It appears either as a slot that issues too early, such as a consumer the victim broadcast should have blocked, or as a slot that never issues. A wrong age or holder record surfaces in the completion cycle itself: the victim index or the stolen register differs from what the program order of finished holders predicts. Lost finished state appears only at retirement, when the head fails to fire or reports the wrong register. Retire order and queue fullness are therefore checked after every steal scenario.

// File: rtl/issue_queue_vp.sv
module issue_queue_vp #(
  parameter int DEPTH = 8,
  parameter int TW    = 6,
  parameter int PW    = 6,
  parameter int CW    = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_valid,
  input  logic [TW-1:0] disp_dst,
  input  logic [TW-1:0] disp_src0,
  input  logic          disp_rdy0,
  input  logic [TW-1:0] disp_src1,
  input  logic          disp_rdy1,
  output logic          disp_ready,
  output logic [IW-1:0] disp_idx,
  input  logic          iss_en,
  output logic          iss_valid,
  output logic [IW-1:0] iss_idx,
  output logic [TW-1:0] iss_dst,
  input  logic          cmp_valid,
  input  logic [IW-1:0] cmp_idx,
  input  logic          cmp_grant,
  input  logic [PW-1:0] cmp_preg,
  output logic          cmp_got,
  output logic [PW-1:0] cmp_preg_out,
  output logic          cmp_stole,
  output logic          vic_valid,
  output logic [IW-1:0] vic_idx,
  output logic [TW-1:0] vic_tag,
  input  logic          wk_valid,
  input  logic [TW-1:0] wk_tag,
  input  logic          ret_en,
  output logic          ret_fire,
  output logic [TW-1:0] ret_dst,
  output logic [PW-1:0] ret_preg,
  output logic [CW-1:0] steal_cnt,
  output logic [CW-1:0] reexec_cnt
);

  logic [DEPTH-1:0] vld, issd, fin, hasp, rdy0, rdy1;
  logic [TW-1:0]    dst  [DEPTH];
  logic [TW-1:0]    src0 [DEPTH];
  logic [TW-1:0]    src1 [DEPTH];
  logic [PW-1:0]    preg [DEPTH];
  logic [IW-1:0]    head, tail;
  logic [IW:0]      cnt;

  logic          sel_found, vic_found;
  logic [IW-1:0] sel_i, vic_i, cmp_age;

  assign disp_ready = cnt != (IW+1)'(DEPTH);
  assign disp_idx   = tail;
  wire   disp_fire  = disp_valid && disp_ready;

  // R3: oldest ready unissued entry, scanned from the youngest down
  always_comb begin
    logic [IW-1:0] j;
    sel_found = 1'b0;
    sel_i     = '0;
    for (int k = DEPTH-1; k >= 0; k--) begin
      j = head + IW'(k);
      if (vld[j] && !issd[j] && rdy0[j] && rdy1[j]) begin
        sel_found = 1'b1;
        sel_i     = j;
      end
    end
  end

  // R7/R10: youngest finished holder younger than the requester
  assign cmp_age = cmp_idx - head;
  always_comb begin
    logic [IW-1:0] j;
    vic_found = 1'b0;
    vic_i     = '0;
    for (int k = 0; k < DEPTH; k++) begin
      j = head + IW'(k);
      if (vld[j] && fin[j] && hasp[j] && IW'(k) > cmp_age) begin
        vic_found = 1'b1;
        vic_i     = j;
      end
    end
  end

  assign iss_valid    = iss_en && sel_found;
  assign iss_idx      = sel_i;
  assign iss_dst      = dst[sel_i];
  assign cmp_stole    = cmp_valid && !cmp_grant && vic_found;
  assign cmp_got      = cmp_valid && (cmp_grant || vic_found);
  assign cmp_preg_out = cmp_grant ? cmp_preg : preg[vic_i];
  assign vic_valid    = cmp_stole;
  assign vic_idx      = vic_i;
  assign vic_tag      = dst[vic_i];
  assign ret_fire     = ret_en && vld[head] && fin[head] && hasp[head];
  assign ret_dst      = dst[head];
  assign ret_preg     = preg[head];

  wire kill_d0 = vic_valid && disp_src0 == vic_tag;
  wire kill_d1 = vic_valid && disp_src1 == vic_tag;
  wire wake_d0 = wk_valid && disp_src0 == wk_tag;
  wire wake_d1 = wk_valid && disp_src1 == wk_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; issd <= '0; fin <= '0; hasp <= '0; rdy0 <= '0; rdy1 <= '0;
      head <= '0; tail <= '0; cnt <= '0;
      steal_cnt <= '0; reexec_cnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        dst[i] <= '0; src0[i] <= '0; src1[i] <= '0; preg[i] <= '0;
      end
    end else begin
      // R4/R8: victim clear has priority over wakeup, unissued entries only
      for (int i = 0; i < DEPTH; i++) begin
        if (vld[i] && !issd[i]) begin
          if (vic_valid && src0[i] == vic_tag)    rdy0[i] <= 1'b0;
          else if (wk_valid && src0[i] == wk_tag) rdy0[i] <= 1'b1;
          if (vic_valid && src1[i] == vic_tag)    rdy1[i] <= 1'b0;
          else if (wk_valid && src1[i] == wk_tag) rdy1[i] <= 1'b1;
        end
      end
      if (iss_valid) issd[sel_i] <= 1'b1;
      if (cmp_valid) begin
        if (cmp_got) begin
          fin[cmp_idx]  <= 1'b1;
          hasp[cmp_idx] <= 1'b1;
          preg[cmp_idx] <= cmp_preg_out;
        end else begin
          issd[cmp_idx] <= 1'b0;
        end
        if (!cmp_grant) reexec_cnt <= reexec_cnt + CW'(1);
      end
      if (cmp_stole) begin
        fin[vic_i]  <= 1'b0;
        hasp[vic_i] <= 1'b0;
        issd[vic_i] <= 1'b0;
        steal_cnt   <= steal_cnt + CW'(1);
      end
      if (disp_fire) begin
        vld[tail]  <= 1'b1;
        issd[tail] <= 1'b0;
        fin[tail]  <= 1'b0;
        hasp[tail] <= 1'b0;
        dst[tail]  <= disp_dst;
        src0[tail] <= disp_src0;
        src1[tail] <= disp_src1;
        rdy0[tail] <= (disp_rdy0 || wake_d0) && !kill_d0;
        rdy1[tail] <= (disp_rdy1 || wake_d1) && !kill_d1;
        tail       <= tail + IW'(1);
      end
      // R5/R11: slots leave only through in-order retirement
      if (ret_fire) begin
        vld[head] <= 1'b0;
        head      <= head + IW'(1);
      end
      cnt <= cnt + (IW+1)'(disp_fire) - (IW+1)'(ret_fire);
    end
  end

endmodule

// File: rtl/issue_queue_vp_chk.sv
module issue_queue_vp_chk #(
  parameter int IW = 3,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_valid,
  input logic [IW-1:0] iss_idx,
  input logic          cmp_valid,
  input logic          cmp_grant,
  input logic [IW-1:0] cmp_idx,
  input logic          vic_valid,
  input logic [IW-1:0] vic_idx,
  input logic [IW-1:0] head,
  input logic [CW-1:0] steal_cnt,
  input logic [CW-1:0] reexec_cnt
);

  logic [IW-1:0] va, ca;
  assign va = vic_idx - head;
  assign ca = cmp_idx - head;

  assert_steal_needs_denial_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> cmp_valid && !cmp_grant);

  assert_victim_younger_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> va > ca);

  assert_steal_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |=> steal_cnt == $past(steal_cnt) + CW'(1));

  assert_reexec_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !cmp_grant) |=> reexec_cnt == $past(reexec_cnt) + CW'(1));

  assert_no_double_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> !(iss_valid && iss_idx == $past(iss_idx)));

endmodule

bind issue_queue_vp issue_queue_vp_chk #(.IW(IW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_idx(iss_idx),
  .cmp_valid(cmp_valid), .cmp_grant(cmp_grant), .cmp_idx(cmp_idx),
  .vic_valid(vic_valid), .vic_idx(vic_idx), .head(head),
  .steal_cnt(steal_cnt), .reexec_cnt(reexec_cnt)
);

// File: tb/test_issue_queue_vp.sv
module test_issue_queue_vp;
  localparam int DEPTH = 8, TW = 6, PW = 6, CW = 16, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 0, disp_rdy0 = 0, disp_rdy1 = 0, iss_en = 0;
  logic [TW-1:0] disp_dst = 0, disp_src0 = 0, disp_src1 = 0, wk_tag = 0;
  logic cmp_valid = 0, cmp_grant = 0, wk_valid = 0, ret_en = 0;
  logic [IW-1:0] cmp_idx = 0;
  logic [PW-1:0] cmp_preg = 0;
  logic disp_ready, iss_valid, cmp_got, cmp_stole, vic_valid, ret_fire;
  logic [IW-1:0] disp_idx, iss_idx, vic_idx;
  logic [TW-1:0] iss_dst, vic_tag, ret_dst;
  logic [PW-1:0] cmp_preg_out, ret_preg;
  logic [CW-1:0] steal_cnt, reexec_cnt;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  issue_queue_vp #(.DEPTH(DEPTH), .TW(TW), .PW(PW), .CW(CW)) i_issue_queue_vp (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_dst(disp_dst), .disp_src0(disp_src0),
    .disp_rdy0(disp_rdy0), .disp_src1(disp_src1), .disp_rdy1(disp_rdy1),
    .disp_ready(disp_ready), .disp_idx(disp_idx),
    .iss_en(iss_en), .iss_valid(iss_valid), .iss_idx(iss_idx), .iss_dst(iss_dst),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_grant(cmp_grant), .cmp_preg(cmp_preg),
    .cmp_got(cmp_got), .cmp_preg_out(cmp_preg_out), .cmp_stole(cmp_stole),
    .vic_valid(vic_valid), .vic_idx(vic_idx), .vic_tag(vic_tag),
    .wk_valid(wk_valid), .wk_tag(wk_tag),
    .ret_en(ret_en), .ret_fire(ret_fire), .ret_dst(ret_dst), .ret_preg(ret_preg),
    .steal_cnt(steal_cnt), .reexec_cnt(reexec_cnt));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    disp_valid = 0; cmp_valid = 0; wk_valid = 0;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0; iss_en = 0; ret_en = 0;
    tick(); tick();
    rst_n = 1;
    tick();
  endtask

  task automatic dispatch(int d, int s0, int r0, int s1, int r1);
    disp_valid = 1; disp_dst = TW'(d);
    disp_src0 = TW'(s0); disp_rdy0 = r0[0];
    disp_src1 = TW'(s1); disp_rdy1 = r1[0];
    tick();
  endtask

  task automatic complete(int idx, int grant, int pr);
    cmp_valid = 1; cmp_idx = IW'(idx); cmp_grant = grant[0]; cmp_preg = PW'(pr);
    #1;
  endtask

  task automatic wake(int t);
    wk_valid = 1; wk_tag = TW'(t);
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    ret_en = 1; #1;
    chk("R1 disp_ready", disp_ready, 1);
    chk("R1 iss_valid", iss_valid, 0);
    chk("R1 ret_fire", ret_fire, 0);
    chk("R1 steal_cnt", steal_cnt, 0);
    chk("R1 reexec_cnt", reexec_cnt, 0);
    ret_en = 0;

    // Sweep A: groups of waiting entries woken out of order
    for (int k = 0; k < DEPTH; k++) begin
      chk("R2 ready before fill", disp_ready, 1);
      chk("R2 slot index", disp_idx, k);
      dispatch(8 + k, 40 + (k % 3), 0, 1, 1);
    end
    chk("R2 full", disp_ready, 0);
    iss_en = 1; #1;
    chk("R3 nothing ready", iss_valid, 0);
    for (int gi = 0; gi < 3; gi++) begin
      int g;
      g = (gi + 2) % 3;
      wake(40 + g);
      for (int k = 0; k < DEPTH; k++) begin
        if (k % 3 == g) begin
          chk("R3 issue valid", iss_valid, 1);
          chk("R3 oldest index", iss_idx, k);
          chk("R3 issue dst", iss_dst, 8 + k);
          tick();
        end
      end
      chk("R3 group drained", iss_valid, 0);
    end
    chk("R5 full after issue", disp_ready, 0);

    // Scenario B: steal, victim broadcast, re-execution, retire
    do_reset();
    iss_en = 1;
    for (int k = 0; k < 6; k++) dispatch(10 + k, 1, 1, 2, 1);
    tick(); tick();
    iss_en = 0;
    dispatch(16, 14, 0, 2, 1);
    dispatch(17, 14, 0, 2, 1);
    complete(1, 1, 31); chk("R5 grant got", cmp_got, 1); tick();
    complete(3, 1, 33); tick();
    complete(4, 1, 34); tick();
    wake(14);
    iss_en = 1; #1;
    chk("R3 oldest of woken pair", iss_idx, 6);
    tick();
    iss_en = 0;
    complete(0, 0, 0);
    wk_valid = 1; wk_tag = 14; #1;
    chk("R7 stole", cmp_stole, 1);
    chk("R7 vic_valid", vic_valid, 1);
    chk("R7 youngest holder", vic_idx, 4);
    chk("R7 vic_tag", vic_tag, 14);
    chk("R7 stolen preg", cmp_preg_out, 34);
    chk("R7 got", cmp_got, 1);
    tick();
    chk("R7 steal_cnt", steal_cnt, 1);
    chk("R6 reexec_cnt after steal", reexec_cnt, 1);
    iss_en = 1; #1;
    chk("R9 victim reissues", iss_valid, 1);
    chk("R9 victim index", iss_idx, 4);
    tick();
    chk("R8 dependent blocked, issued not reissued", iss_valid, 0);
    complete(4, 1, 44); tick();
    chk("R4 victim wins over wakeup", iss_valid, 0);
    wake(14);
    chk("R4 wakeup after recompute", iss_idx, 7);
    chk("R4 wakeup valid", iss_valid, 1);
    tick();
    complete(5, 0, 0);
    chk("R10 no older victim", cmp_stole, 0);
    chk("R10 no broadcast", vic_valid, 0);
    chk("R6 no register", cmp_got, 0);
    tick();
    chk("R6 reexec_cnt", reexec_cnt, 2);
    chk("R6 steal_cnt unchanged", steal_cnt, 1);
    chk("R6 requester reissues", iss_valid, 1);
    chk("R6 requester index", iss_idx, 5);
    tick();
    iss_en = 0;
    chk("R5 still full", disp_ready, 0);
    ret_en = 1; #1;
    chk("R11 head fires", ret_fire, 1);
    chk("R11 head dst", ret_dst, 10);
    chk("R11 head preg", ret_preg, 34);
    tick();
    chk("R11 second dst", ret_dst, 11);
    chk("R11 second preg", ret_preg, 31);
    tick();
    chk("R11 unfinished head blocks", ret_fire, 0);
    chk("R2 slots freed", disp_ready, 1);
    complete(2, 1, 32); tick();
    chk("R11 third fires", ret_fire, 1);
    chk("R11 third preg", ret_preg, 32);
    ret_en = 0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule